// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two IEEE-754 double-precision operands, each supplied as a raw 64-bit word. It reduces the comparison to a one-hot condition nibble with four flags: less-than, greater-than, equal and unordered. The nibble is merged into one 4-bit field of a 32-bit condition register. The same nibble is also merged into the condition-code bits of a floating-point status word.

The instruction word supplies the target field and the extended opcode. The caller presents the current condition register and status word together with the operands and pulses `start`. One clock later the block returns both updated words and a one-cycle `done`. If the instruction encoding cannot be executed, `illegal` is raised alongside `done` and both words come back unchanged.

Both the ordered and the unordered compare forms give the same result. Trapping on signalling NaNs and setting exception bits are not part of this block.

Top module: `fcmp_unit`

## Requirements
- R1: The condition nibble is one-hot, with bit 3 first: 4'b1000 means A less than B, 4'b0100 means A greater than B, 4'b0010 means equal and 4'b0001 means unordered.
- R2: When either operand has an all-ones exponent field (bits [62:52] all set, which covers NaN and infinity), the nibble is 4'b0001 and no magnitude ordering is done.
- R3: Positive zero and negative zero compare equal, in either order.
- R4: The ordering takes the sign bit (bit 63) into account. Any negative non-zero value is less than any positive value. Between two negative values, the one with the larger magnitude is less.
- R5: The target field index is instr[25:23]. Field n occupies cr_out bits [31-4n : 28-4n], so field 0 is the top nibble. On a legal compare that field takes the nibble and every other bit of cr_out equals cr_in.
- R6: On a legal compare, fpsw_out equals fpsw_in with bit 15 cleared and bits [14:11] replaced by the nibble. All other bits are kept.
- R7: If instr[22:21] is not 2'b00, the compare is illegal: illegal is 1 together with done, cr_out equals cr_in and fpsw_out equals fpsw_in.
- R8: The extended opcode instr[10:1] must be 0 (unordered form) or 32 (ordered form). Both forms give the same outputs. Any other value makes the compare illegal, with outputs as in R7.
- R9: The outputs and done are registered from the inputs sampled on the clock edge where start is 1. done is high for exactly the following cycle. Without start, cr_out, fpsw_out and illegal keep their values, and illegal stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compare using the present inputs |
| op_a | input | 64 | First operand (double-precision bit pattern) |
| op_b | input | 64 | Second operand (double-precision bit pattern) |
| instr | input | 32 | Instruction word: target field [25:21], extended opcode [10:1] |
| cr_in | input | 32 | Current condition register |
| fpsw_in | input | 32 | Current floating-point status word |
| cr_out | output | 32 | Updated condition register |
| fpsw_out | output | 32 | Updated status word |
| done | output | 1 | One-cycle pulse, one cycle after start |
| illegal | output | 1 | Instruction encoding rejected; valid with done |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent and a 52-bit fraction. With these values the reference model can convert operands to the simulator's native double type and compare them there. It therefore orders subnormals, signed zeros and mixed signs with no shared logic. All eight condition fields, every misaligned target code and both legal extended opcodes are in reach. Random operand words are skewed toward zero, all-ones and equal exponents, so that unordered results and near-equal magnitudes occur often.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FIELD_W   = 4;
  localparam int FIDX_W    = 3;
  localparam int NFIELD    = 1 << FIDX_W;
  localparam int CRW       = FIELD_W * NFIELD;
  localparam int XO_W      = 10;
  localparam int FPCC_LSB  = 11;
  localparam int FPCC_CLR  = 5;

  localparam logic [XO_W-1:0] XO_CMP_UNORD = 10'd0;
  localparam logic [XO_W-1:0] XO_CMP_ORD   = 10'd32;

  localparam logic [FIELD_W-1:0] CC_LT = 4'b1000;
  localparam logic [FIELD_W-1:0] CC_GT = 4'b0100;
  localparam logic [FIELD_W-1:0] CC_EQ = 4'b0010;
  localparam logic [FIELD_W-1:0] CC_UN = 4'b0001;

  // Mask selecting field idx, field 0 being the most significant nibble.
  function automatic logic [CRW-1:0] field_mask(input logic [FIDX_W-1:0] idx);
    logic [CRW-1:0] top;
    top = {{FIELD_W{1'b1}}, {(CRW-FIELD_W){1'b0}}};
    return top >> (FIELD_W * int'(idx));
  endfunction

  function automatic logic [CRW-1:0] put_field(input logic [CRW-1:0] word,
                                               input logic [FIDX_W-1:0] idx,
                                               input logic [FIELD_W-1:0] nib);
    logic [CRW-1:0] placed;
    placed = {nib, {(CRW-FIELD_W){1'b0}}} >> (FIELD_W * int'(idx));
    return (word & ~field_mask(idx)) | placed;
  endfunction

  function automatic logic [CRW-1:0] put_fpcc(input logic [CRW-1:0] sw,
                                              input logic [FIELD_W-1:0] nib);
    logic [CRW-1:0] clr;
    clr = {{(CRW-FPCC_CLR){1'b0}}, {FPCC_CLR{1'b1}}} << FPCC_LSB;
    return (sw & ~clr) | ({{(CRW-FIELD_W){1'b0}}, nib} << FPCC_LSB);
  endfunction
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [31:0]       instr,
  output logic [FIDX_W-1:0] field_idx,
  output logic              bad_field,
  output logic              bad_xo,
  output logic              ordered
);
  logic [4:0]      tgt;
  logic [XO_W-1:0] xo;
  logic            unused_bits;

  assign tgt         = instr[25:21];
  assign xo          = instr[10:1];
  assign unused_bits = ^{instr[31:26], instr[20:11], instr[0]};

  assign field_idx = tgt[4:2];
  assign bad_field = |tgt[1:0];
  assign ordered   = (xo == XO_CMP_ORD);
  assign bad_xo    = !(xo == XO_CMP_UNORD || ordered);

  always_comb begin
    if (!bad_xo) begin
      AST_LEGAL_XO: assert (xo[9:6] == 4'd0 && xo[4:0] == 5'd0) else $error("xo decode"); // R8
    end
  end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0]  op_a,
  input  logic [EXP_W+MAN_W:0]  op_b,
  output logic [FIELD_W-1:0]    nibble,
  output logic                  special
);
  localparam int OP_W  = 1 + EXP_W + MAN_W;
  localparam int MAG_W = OP_W - 1;

  logic [OP_W-1:0] ops [2];
  logic [1:0]      is_spec;
  logic [1:0]      is_zero;
  logic [1:0]      sgn;
  logic [MAG_W-1:0] mag [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    assign sgn[g]     = ops[g][OP_W-1];
    assign mag[g]     = ops[g][MAG_W-1:0];
    assign is_spec[g] = &ops[g][MAG_W-1 -: EXP_W];
    assign is_zero[g] = ~|mag[g];
  end

  // Sign-magnitude ordering of two ordinary operands.
  function automatic logic [FIELD_W-1:0] order_cc(input logic sa, input logic sb,
                                                  input logic [MAG_W-1:0] ma,
                                                  input logic [MAG_W-1:0] mb,
                                                  input logic both_zero);
    if (both_zero)      return CC_EQ;
    if (sa != sb)       return sa ? CC_LT : CC_GT;
    if (ma == mb)       return CC_EQ;
    return ((ma > mb) ^ sa) ? CC_GT : CC_LT;
  endfunction

  assign special = |is_spec;
  assign nibble  = special ? CC_UN
                 : order_cc(sgn[0], sgn[1], mag[0], mag[1], &is_zero);

  always_comb begin
    AST_ONEHOT_CC: assert ($countones(nibble) == 1) else $error("cc not one-hot"); // R1
    if (special) begin
      AST_SPECIAL_UN: assert (nibble == CC_UN) else $error("special not unordered"); // R2
    end
    if (!special && is_zero[0] && is_zero[1]) begin
      AST_ZERO_EQ: assert (nibble == CC_EQ) else $error("zeros unequal"); // R3
    end
    if (!special && sgn[0] && !sgn[1] && !(is_zero[0] && is_zero[1])) begin
      AST_NEG_BELOW_POS: assert (nibble == CC_LT) else $error("sign order"); // R4
    end
  end
endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge
  import fcmp_pkg::*;
(
  input  logic [CRW-1:0]     cr_in,
  input  logic [CRW-1:0]     fpsw_in,
  input  logic [FIDX_W-1:0]  field_idx,
  input  logic [FIELD_W-1:0] nibble,
  input  logic               write_en,
  output logic [CRW-1:0]     cr_nxt,
  output logic [CRW-1:0]     fpsw_nxt
);
  logic [CRW-1:0] cr_ins;
  logic [CRW-1:0] sw_ins;

  assign cr_ins   = put_field(cr_in, field_idx, nibble);
  assign sw_ins   = put_fpcc(fpsw_in, nibble);
  assign cr_nxt   = write_en ? cr_ins : cr_in;
  assign fpsw_nxt = write_en ? sw_ins : fpsw_in;

  always_comb begin
    AST_OTHER_FIELDS_KEPT: assert (((cr_nxt ^ cr_in) & ~field_mask(field_idx)) == '0)
      else $error("foreign CR field touched"); // R5
    AST_SW_HIGH_KEPT: assert (fpsw_nxt[CRW-1:16] == fpsw_in[CRW-1:16] && fpsw_nxt[10:0] == fpsw_in[10:0])
      else $error("status bits outside cc touched"); // R6
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  input  logic [31:0]            instr,
  input  logic [31:0]            cr_in,
  input  logic [31:0]            fpsw_in,
  output logic [31:0]            cr_out,
  output logic [31:0]            fpsw_out,
  output logic                   done,
  output logic                   illegal
);
  logic [FIDX_W-1:0]  field_idx;
  logic               bad_field, bad_xo, ordered, reject;
  logic [FIELD_W-1:0] nibble;
  logic               special;
  logic [CRW-1:0]     cr_nxt, fpsw_nxt;
  logic               unused_ord;

  fcmp_decode u_dec (
    .instr(instr), .field_idx(field_idx), .bad_field(bad_field),
    .bad_xo(bad_xo), .ordered(ordered)
  );

  fcmp_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
    .op_a(op_a), .op_b(op_b), .nibble(nibble), .special(special)
  );

  // Both compare forms behave alike; no trap is raised for the ordered one.
  assign unused_ord = ordered ^ special;
  assign reject     = bad_field | bad_xo;

  fcmp_merge u_mrg (
    .cr_in(cr_in), .fpsw_in(fpsw_in), .field_idx(field_idx), .nibble(nibble),
    .write_en(!reject), .cr_nxt(cr_nxt), .fpsw_nxt(fpsw_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_out   <= '0;
      fpsw_out <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      done    <= start;
      illegal <= start & reject;
      if (start) begin
        cr_out   <= cr_nxt;
        fpsw_out <= fpsw_nxt;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done) else $error("done missing"); // R9
  AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && !illegal) else $error("stray done"); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cr_out) && $stable(fpsw_out)) else $error("outputs moved"); // R9
  AST_ILLEGAL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    start && reject |=> illegal && cr_out == $past(cr_in) && fpsw_out == $past(fpsw_in))
    else $error("illegal wrote"); // R7
  AST_FPCC_BIT15_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !reject |=> !fpsw_out[15] && !illegal) else $error("bit 15 set"); // R6
endmodule

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [31:0] instr = '0, cr_in = '0, fpsw_in = '0;
  logic [31:0] cr_out, fpsw_out;
  logic        done, illegal;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fcmp_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .instr(instr), .cr_in(cr_in), .fpsw_in(fpsw_in), .cr_out(cr_out),
    .fpsw_out(fpsw_out), .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input int fld, input int low, input int xo);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'd63;
    w[25:23] = fld[2:0];
    w[22:21] = low[1:0];
    w[10:1]  = xo[9:0];
    return w;
  endfunction

  function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (&a[62:52] || &b[62:52]) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic logic [31:0] ref_cr(input logic [31:0] cr, input int fld, input logic [3:0] nib);
    logic [31:0] r;
    for (int i = 0; i < 8; i++) begin
      if (i == fld) r[31-4*i -: 4] = nib;
      else          r[31-4*i -: 4] = cr[31-4*i -: 4];
    end
    return r;
  endfunction

  task automatic run_cmp(input logic [63:0] a, input logic [63:0] b, input int fld,
                         input int low, input int xo, input logic [31:0] cr,
                         input logic [31:0] sw, input string tag);
    logic [3:0]  nib;
    logic [31:0] ecr, esw;
    bit          bad;
    @(negedge clk);
    op_a = a; op_b = b; instr = mk_instr(fld, low, xo);
    cr_in = cr; fpsw_in = sw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = (low != 0) || !(xo == 0 || xo == 32);
    nib = ref_cc(a, b);
    ecr = bad ? cr : ref_cr(cr, fld, nib);
    esw = bad ? sw : {sw[31:16], 1'b0, nib, sw[10:0]};
    chk(done == 1'b1, {"R9 done ", tag}, 64'(done), 64'd1);
    chk(illegal == bad, {(bad ? "R7/R8 illegal " : "R8 legal "), tag}, 64'(illegal), 64'(bad));
    chk(cr_out == ecr, {"R1 R5 cr ", tag}, 64'(cr_out), 64'(ecr));
    chk(fpsw_out == esw, {"R6 sw ", tag}, 64'(fpsw_out), 64'(esw));
    // Scramble inputs while idle; outputs must hold and done must drop.
    op_a = ~a; cr_in = ~cr; fpsw_in = ~sw;
    @(negedge clk);
    chk(done == 1'b0 && illegal == 1'b0, {"R9 pulse ", tag}, 64'({done, illegal}), 64'd0);
    chk(cr_out == ecr && fpsw_out == esw, {"R9 hold ", tag}, 64'(cr_out), 64'(ecr));
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 9);
    if (k == 0) v[62:52] = '1;
    else if (k == 1) v[62:0] = '0;
    else if (k == 2) v[62:52] = '0;
    else if (k < 6) v[62:52] = 11'h3FF + 11'($urandom_range(0, 3));
    return v;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cr_out == '0 && fpsw_out == '0 && !done && !illegal, "R9 reset", 64'(cr_out), 64'd0);
    rst_n = 1'b1;

    // Signed zeros (R3)
    run_cmp(64'h0, 64'h8000_0000_0000_0000, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 +0/-0");
    run_cmp(64'h8000_0000_0000_0000, 64'h0, 3, 0, 32, 32'h1234_5678, 32'h0, "R3 -0/+0");
    // Sign-aware ordering (R4)
    run_cmp($realtobits(-2.0), $realtobits(-1.0), 1, 0, 0, 32'h0, 32'h0, "R4 -2<-1");
    run_cmp($realtobits(-1.0), $realtobits(-2.0), 2, 0, 0, 32'h0, 32'h0, "R4 -1>-2");
    run_cmp($realtobits(-1.0e300), $realtobits(1.0e-300), 4, 0, 0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, "R4 mixed");
    run_cmp($realtobits(3.5), $realtobits(3.5), 5, 0, 32, 32'h0, 32'h0000_8000, "R1 equal");
    // Specials (R2)
    run_cmp(64'h7FF0_0000_0000_0000, $realtobits(1.0), 6, 0, 0, 32'h0, 32'h0, "R2 inf");
    run_cmp($realtobits(1.0), 64'hFFF8_0000_0000_0001, 7, 0, 32, 32'hFFFF_FFFF, 32'h0, "R2 nan");
    // Every field (R5)
    for (int f = 0; f < 8; f++)
      run_cmp($realtobits(1.0), $realtobits(2.0), f, 0, 0, 32'h9999_9999, 32'h0, "R5 field");
    // Illegal encodings (R7, R8)
    for (int l = 1; l < 4; l++)
      run_cmp($realtobits(1.0), $realtobits(2.0), 2, l, 0, 32'hCAFE_F00D, 32'h0000_F800, "R7 misaligned");
    run_cmp($realtobits(1.0), $realtobits(2.0), 2, 0, 5, 32'hCAFE_F00D, 32'h1, "R8 bad xo");
    run_cmp($realtobits(1.0), $realtobits(2.0), 2, 0, 544, 32'hCAFE_F00D, 32'h1, "R8 bad xo hi");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = rnd_op();
      b = ($urandom_range(0, 7) == 0) ? a : rnd_op();
      run_cmp(a, b, $urandom_range(0, 7), ($urandom_range(0, 9) == 0) ? 1 : 0,
              ($urandom_range(0, 1) == 1) ? 32 : 0, $urandom, $urandom, "R4 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule